// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is one DMA channel that moves data between a single peripheral data port and memory. Software loads two buffer descriptors, each a start address and a transfer count, and enables them. The channel works through the active descriptor one beat at a time. It launches one beat for each peripheral request it sees while idle. When the active count reaches zero, the channel flags that buffer as done, disables it and swaps to the other descriptor. While the channel handles one buffer, software can refill the other, which gives gap-free streaming.

A small register port holds all the channel state. The mode word has two write addresses: one sets the bits written as 1 and the other clears them, so software never needs a read-modify-write. The master port issues single beats. Each beat is one read followed by one write, and the direction bit picks which side is the source. When software drops the run bit, the channel finishes the beat in flight and then reports that it has stopped through a read-only halted flag.

Top module: `dma_pingpong_chan`

## Requirements
- R1: After reset the mode word reads 0x0000_0040, with only halted set. A write to offset 0x00 sets each mode bit written as 1. A write to offset 0x04 clears each mode bit written as 1. Reading either offset returns the mode word. Bits 14 and 31:24 always read 0.
- R2: The peripheral address sits at 0x08. Buffer 0 start is at 0x0C and its count at 0x10. Buffer 1 start is at 0x14 and its count at 0x18. A count word keeps bits 15:0 (the count) and bits 19:16 (the high memory address bits), and reads 0 in bits 31:20.
- R3: Mode bit 12 selects the direction. With bit 12 at 0, a beat reads memory at {high bits, start} and writes that data to the peripheral at {mode[23:20], peripheral address}. With bit 12 at 1, the beat reads the peripheral and writes memory.
- R4: After each beat, the active buffer's count drops by 1. Its start address advances by 1, 2, 4 or 4 bytes when mode[10:9] is 0, 1, 2 or 3.
- R5: When the active count reaches 0, the channel sets that buffer's done bit (bit 1 for buffer 0, bit 3 for buffer 1), clears its enable (bit 0 or bit 2) and toggles the active bit (bit 4).
- R6: After a swap, the channel carries on with the other buffer if that buffer is enabled. If the active buffer is disabled, no beat is issued, even with the request held.
- R7: A done bit stays set until software writes a 1 to it at offset 0x04. A clear write with 0 in the done positions leaves them unchanged.
- R8: The interrupt output equals mode bit 7 ANDed with the OR of the two done bits.
- R9: The halted bit (bit 6) cannot be written. Once the run bit (bit 5) is cleared, the beat in flight completes, halted then reads 1 and no further beat starts. Setting run clears halted.
- R10: If the active buffer is enabled with a count of 0, it completes as in R5 without issuing a beat.
- R11: Each idle cycle with the request high and an enabled buffer holding a nonzero count launches exactly one beat. No beat starts without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| perReq | input | 1 | Peripheral transfer request |
| mReq | output | 1 | Master beat phase valid |
| mWrite | output | 1 | Master phase is a write |
| mAddr | output | 36 | Master address |
| mWdata | output | 32 | Master write data |
| mRdata | input | 32 | Master read data |
| mAck | input | 1 | Master phase accepted |
| irq | output | 1 | Buffer-done interrupt |

## Verification
The bench sweeps every width code and both directions through a three-beat buffer followed by a two-beat buffer. After each beat it checks the source address, destination address, data, residual count and start pointer. These checks catch an address step that is off by a width code, a direction swap on only one phase, or a count taken from the idle buffer. At the swap it checks the done, enable and active bits, which catches a design that loses the toggle or keeps issuing beats after both buffers have drained. It also clears run in mid-beat, which catches a design that aborts the write or raises halted early. It also arms a zero-length buffer, which catches a design that hangs or wraps the count to 65535.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  // mode word bit positions (software decodes these)
  localparam int BIT_EN0 = 0;
  localparam int BIT_DN0 = 1;
  localparam int BIT_EN1 = 2;
  localparam int BIT_DN1 = 3;
  localparam int BIT_ACT = 4;
  localparam int BIT_RUN = 5;
  localparam int BIT_HLT = 6;
  localparam int BIT_IE  = 7;
  localparam int BIT_DIR = 12;
  localparam int DW_LSB  = 9;
  localparam int DAH_LSB = 20;

  // writable mode bits: everything but halted (6), bit 14 and 31:24
  localparam logic [31:0] MODE_WMASK = 32'h00FF_BFBF;
  localparam logic [31:0] MODE_RST   = 32'h0000_0040;

  // register offsets
  localparam int OFF_SET = 8'h00;
  localparam int OFF_CLR = 8'h04;
  localparam int OFF_PER = 8'h08;
  localparam int OFF_S0  = 8'h0C;
  localparam int OFF_C0  = 8'h10;
  localparam int OFF_S1  = 8'h14;
  localparam int OFF_C1  = 8'h18;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} beatState_t;

  typedef struct packed {
    logic captureData;
    logic beatDone;
    logic bufFinish;
    logic setHalt;
    logic clrHalt;
    logic wrPhase;
  } dmaStrobes_t;

  function automatic logic [2:0] stepBytes(input logic [1:0] dw);
    case (dw)
      2'd0:    stepBytes = 3'd1;
      2'd1:    stepBytes = 3'd2;
      default: stepBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int HI_W   = 4,
  parameter int REG_AW = 8,
  localparam int ADDR_W = DATA_W + HI_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  dmaStrobes_t       strb,
  input  logic [DATA_W-1:0] mRdata,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mWdata,
  output logic              irq,
  output logic              run,
  output logic              halted,
  output logic              actEn,
  output logic              actCntZero,
  output logic              actCntOne
);

  logic [31:0]       modeQ, modeNext;
  logic [DATA_W-1:0] perAddrQ;
  logic [DATA_W-1:0] startQ [2];
  logic [CNT_W-1:0]  cntQ   [2];
  logic [HI_W-1:0]   hiQ    [2];
  logic [DATA_W-1:0] dataQ;
  logic              act;
  logic              useMem;
  logic [DATA_W-1:0] stepAddr;

  assign act      = modeQ[BIT_ACT];
  assign stepAddr = DATA_W'(stepBytes(modeQ[DW_LSB +: 2]));

  always_comb begin
    modeNext = modeQ;
    if (regWr && regAddr == REG_AW'(OFF_SET))
      modeNext = modeNext | (32'(regWdata) & MODE_WMASK);
    if (regWr && regAddr == REG_AW'(OFF_CLR))
      modeNext = modeNext & ~(32'(regWdata) & MODE_WMASK);
    if (strb.bufFinish) begin
      modeNext[act ? BIT_EN1 : BIT_EN0] = 1'b0;
      modeNext[act ? BIT_DN1 : BIT_DN0] = 1'b1;
      modeNext[BIT_ACT]                 = ~act;
    end
    if (strb.clrHalt) modeNext[BIT_HLT] = 1'b0;
    if (strb.setHalt) modeNext[BIT_HLT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_RST;
      perAddrQ <= '0;
      dataQ    <= '0;
      for (int b = 0; b < 2; b++) begin
        startQ[b] <= '0;
        cntQ[b]   <= '0;
        hiQ[b]    <= '0;
      end
    end else begin
      modeQ <= modeNext;
      if (regWr && regAddr == REG_AW'(OFF_PER)) perAddrQ <= regWdata;
      if (strb.captureData) dataQ <= mRdata;
      for (int b = 0; b < 2; b++) begin
        if (strb.beatDone && int'(act) == b) begin
          cntQ[b]   <= cntQ[b] - 1'b1;
          startQ[b] <= startQ[b] + stepAddr;
        end else begin
          if (regWr && regAddr == REG_AW'(b == 0 ? OFF_S0 : OFF_S1))
            startQ[b] <= regWdata;
          if (regWr && regAddr == REG_AW'(b == 0 ? OFF_C0 : OFF_C1)) begin
            cntQ[b] <= regWdata[CNT_W-1:0];
            hiQ[b]  <= regWdata[CNT_W +: HI_W];
          end
        end
      end
    end
  end

  always_comb begin
    case (regAddr)
      REG_AW'(OFF_SET), REG_AW'(OFF_CLR): regRdata = DATA_W'(modeQ);
      REG_AW'(OFF_PER): regRdata = perAddrQ;
      REG_AW'(OFF_S0):  regRdata = startQ[0];
      REG_AW'(OFF_C0):  regRdata = DATA_W'({hiQ[0], cntQ[0]});
      REG_AW'(OFF_S1):  regRdata = startQ[1];
      REG_AW'(OFF_C1):  regRdata = DATA_W'({hiQ[1], cntQ[1]});
      default:          regRdata = '0;
    endcase
  end

  // memory side is the source on the read phase when direction is 0
  assign useMem     = (strb.wrPhase == modeQ[BIT_DIR]);
  assign mAddr      = useMem ? {hiQ[act], startQ[act]}
                             : {modeQ[DAH_LSB +: HI_W], perAddrQ};
  assign mWdata     = dataQ;
  assign irq        = modeQ[BIT_IE] & (modeQ[BIT_DN0] | modeQ[BIT_DN1]);
  assign run        = modeQ[BIT_RUN];
  assign halted     = modeQ[BIT_HLT];
  assign actEn      = act ? modeQ[BIT_EN1] : modeQ[BIT_EN0];
  assign actCntZero = (cntQ[act] == '0);
  assign actCntOne  = (cntQ[act] == CNT_W'(1));

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.beatDone && !act) |=> cntQ[0] == $past(cntQ[0]) - 1'b1); // R4
  AST_FINISH_TOGGLES: assert property (@(posedge clk) disable iff (!rstN)
    strb.bufFinish |=> modeQ[BIT_ACT] != $past(modeQ[BIT_ACT])); // R5
  AST_FINISH_SETS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    strb.bufFinish |=> (modeQ[BIT_DN0] | modeQ[BIT_DN1])); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[BIT_DN0] && !(regWr && regAddr == REG_AW'(OFF_CLR))) |=> modeQ[BIT_DN0]); // R7

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        perReq,
  input  logic        mAck,
  input  logic        run,
  input  logic        halted,
  input  logic        actEn,
  input  logic        actCntZero,
  input  logic        actCntOne,
  output dmaStrobes_t strb,
  output logic        mReq
);

  beatState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    mReq      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (!run) begin
          strb.setHalt = !halted;
        end else begin
          strb.clrHalt = halted;
          if (actEn) begin
            if (actCntZero)  strb.bufFinish = 1'b1;
            else if (perReq) stateNext = ST_RD;
          end
        end
      end
      ST_RD: begin
        mReq = 1'b1;
        if (mAck) begin
          strb.captureData = 1'b1;
          stateNext        = ST_WR;
        end
      end
      ST_WR: begin
        mReq         = 1'b1;
        strb.wrPhase = 1'b1;
        if (mAck) begin
          strb.beatDone  = 1'b1;
          strb.bufFinish = actCntOne;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_NO_REQ_WHILE_HALTED: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !mReq); // R9
  AST_HALT_FOLLOWS_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !run) |=> halted); // R9
  AST_NO_LAUNCH_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !perReq) |=> state == ST_IDLE); // R11
  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !actEn) |=> state == ST_IDLE); // R6

endmodule

// File: rtl/dma_pingpong_chan.sv
module dma_pingpong_chan
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int HI_W   = 4,
  parameter int REG_AW = 8,
  localparam int ADDR_W = DATA_W + HI_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              perReq,
  output logic              mReq,
  output logic              mWrite,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mWdata,
  input  logic [DATA_W-1:0] mRdata,
  input  logic              mAck,
  output logic              irq
);

  dmaStrobes_t strb;
  logic run, halted, actEn, actCntZero, actCntOne;

  dma_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .perReq(perReq), .mAck(mAck),
    .run(run), .halted(halted), .actEn(actEn),
    .actCntZero(actCntZero), .actCntOne(actCntOne),
    .strb(strb), .mReq(mReq)
  );

  dma_chan_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W), .HI_W(HI_W), .REG_AW(REG_AW)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strb(strb),
    .mRdata(mRdata), .mAddr(mAddr), .mWdata(mWdata), .irq(irq),
    .run(run), .halted(halted), .actEn(actEn),
    .actCntZero(actCntZero), .actCntOne(actCntOne)
  );

  assign mWrite = strb.wrPhase;

endmodule

// File: tb/sim_dma_pingpong_chan.sv
module sim_dma_pingpong_chan;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        perReq = 1'b0;
  logic        mReq, mWrite, mAck, irq;
  logic [35:0] mAddr;
  logic [31:0] mWdata, mRdata;

  int nChecks = 0;
  int nFail = 0;
  int wrCnt = 0;
  logic [35:0] lastRA, lastWA;
  logic [31:0] lastWD;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] memVal(input logic [35:0] a);
    return a[31:0] ^ {a[35:32], 28'h0} ^ 32'h00C3_3C00;
  endfunction

  assign mAck   = mReq;
  assign mRdata = memVal(mAddr);

  always @(posedge clk) begin
    if (mReq && mAck && !mWrite) lastRA <= mAddr;
    if (mReq && mAck && mWrite) begin
      lastWA <= mAddr;
      lastWD <= mWdata;
      wrCnt  <= wrCnt + 1;
    end
  end

  dma_pingpong_chan u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .perReq(perReq),
    .mReq(mReq), .mWrite(mWrite), .mAddr(mAddr), .mWdata(mWdata),
    .mRdata(mRdata), .mAck(mAck), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; #1;
    d = regRdata;
  endtask

  task automatic pulseReq();
    perReq = 1'b1;
    @(posedge clk); #1;
    perReq = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int w0;
    cyc(3);
    rstN = 1'b1;
    cyc(1);

    // reset state
    regRead(8'h00, rd); chk("R1 reset mode", rd, 32'h40);
    regRead(8'h10, rd); chk("R2 reset count0", rd, 0);
    chk("R8 reset irq", irq, 0);
    chk("R11 reset mReq", mReq, 0);

    // register file
    regWrite(8'h08, 32'h1234_5678); regRead(8'h08, rd); chk("R2 per addr", rd, 32'h1234_5678);
    regWrite(8'h0C, 32'hAAAA_0001); regRead(8'h0C, rd); chk("R2 start0", rd, 32'hAAAA_0001);
    regWrite(8'h10, 32'hFFFB_ABCD); regRead(8'h10, rd); chk("R2 count0 fields", rd, 32'h000B_ABCD);
    regWrite(8'h14, 32'h5555_0002); regRead(8'h14, rd); chk("R2 start1", rd, 32'h5555_0002);
    regWrite(8'h18, 32'h0003_0007); regRead(8'h18, rd); chk("R2 count1", rd, 32'h0003_0007);

    // mode set/clear ports
    regWrite(8'h00, 32'h0000_3F80); regRead(8'h00, rd); chk("R1 set port", rd, 32'h3FC0);
    regRead(8'h04, rd); chk("R1 read at clear offset", rd, 32'h3FC0);
    regWrite(8'h04, 32'hFFFF_FFFF); regRead(8'h00, rd); chk("R9 halted not clearable", rd, 32'h40);
    regWrite(8'h00, 32'hFFFF_C000); regRead(8'h00, rd); chk("R1 upper fields", rd, 32'h00FF_8040);
    regWrite(8'h04, 32'hFFFF_FFFF);

    // done bits and interrupt
    regWrite(8'h00, 32'h0A); regRead(8'h00, rd); chk("R7 done set", rd, 32'h4A);
    chk("R8 irq masked", irq, 0);
    regWrite(8'h00, 32'h80); chk("R8 irq on", irq, 1);
    regWrite(8'h04, 32'h05); regRead(8'h00, rd); chk("R7 zero clear keeps done", rd, 32'hCA);
    regWrite(8'h04, 32'h02); chk("R8 irq with done1 only", irq, 1);
    regRead(8'h00, rd); chk("R7 clear done0", rd, 32'hC8);
    regWrite(8'h04, 32'h08); chk("R8 irq off after clear", irq, 0);
    regWrite(8'h04, 32'hFFFF_FFFF);

    // sweep width and direction
    for (int cfg = 0; cfg < 8; cfg++) begin
      logic [1:0]  dw;
      logic        dir;
      logic [3:0]  hi0, hi1, dah;
      logic [31:0] p, s0, s1, step;
      dw  = 2'(cfg % 4);
      dir = 1'(cfg / 4);
      hi0 = 4'(cfg); hi1 = 4'(cfg + 8); dah = 4'(15 - cfg);
      p   = 32'h4000_0100 + 32'(cfg * 16);
      s0  = 32'h1000_0000 + 32'(cfg * 256);
      s1  = 32'h2000_0000 + 32'(cfg * 256);
      step = (dw == 0) ? 1 : (dw == 1) ? 2 : 4;
      regWrite(8'h04, 32'hFFFF_FFFF);
      regWrite(8'h08, p);
      regWrite(8'h0C, s0); regWrite(8'h10, {12'h0, hi0, 16'd3});
      regWrite(8'h14, s1); regWrite(8'h18, {12'h0, hi1, 16'd2});
      regWrite(8'h00, (32'(dw) << 9) | (32'(dir) << 12) | (32'(dah) << 20) | 32'h25);
      w0 = wrCnt;
      cyc(3);
      regRead(8'h00, rd); chk("R9 run clears halted", rd[6], 0);
      chk("R11 no beat without request", wrCnt, w0);
      for (int b = 0; b < 5; b++) begin
        int k;
        logic [35:0] memA, perA;
        logic [31:0] s;
        logic [3:0] hi;
        s  = (b < 3) ? s0 : s1;
        hi = (b < 3) ? hi0 : hi1;
        k  = (b < 3) ? b : b - 3;
        memA = {hi, s + 32'(k) * step};
        perA = {dah, p};
        w0 = wrCnt;
        pulseReq();
        cyc(4);
        chk("R11 one beat per request", wrCnt, w0 + 1);
        chk("R3 source addr", lastRA, dir ? perA : memA);
        chk("R3 dest addr", lastWA, dir ? memA : perA);
        chk("R3 data", lastWD, memVal(dir ? perA : memA));
        regRead((b < 3) ? 8'h10 : 8'h18, rd);
        chk("R4 count residue", rd[15:0], (b < 3) ? 16'(2 - b) : 16'(4 - b));
        regRead((b < 3) ? 8'h0C : 8'h14, rd);
        chk("R4 start advance", rd, s + 32'(k + 1) * step);
        if (b == 2) begin
          regRead(8'h00, rd); chk("R5 swap to buffer1", rd[4:0], 5'h16);
        end
      end
      regRead(8'h00, rd); chk("R5 both done, active back to 0", rd[4:0], 5'h0A);
      w0 = wrCnt;
      pulseReq(); cyc(4);
      chk("R6 no beat with both disabled", wrCnt, w0);
    end

    // zero-length buffer
    regWrite(8'h04, 32'hFFFF_FFFF);
    regWrite(8'h10, 32'h0);
    w0 = wrCnt;
    regWrite(8'h00, 32'h21);
    cyc(3);
    regRead(8'h00, rd); chk("R10 zero count completes", rd[4:0], 5'h12);
    chk("R10 no beat issued", wrCnt, w0);

    // halt in the middle of a beat
    regWrite(8'h04, 32'hFFFF_FFFF);
    regWrite(8'h0C, 32'h3000_0000); regWrite(8'h10, 32'd5);
    regWrite(8'h00, 32'h21);
    cyc(2);
    w0 = wrCnt;
    pulseReq();
    regWrite(8'h04, 32'h20);
    regRead(8'h00, rd); chk("R9 not halted mid-beat", rd[6], 0);
    cyc(3);
    chk("R9 beat in flight completes", wrCnt, w0 + 1);
    regRead(8'h10, rd); chk("R9 count after halt", rd[15:0], 16'd4);
    regRead(8'h00, rd); chk("R9 halted reported", rd[6], 1);
    pulseReq(); cyc(4);
    chk("R9 no beat while halted", wrCnt, w0 + 1);
    regWrite(8'h00, 32'h20);
    cyc(2);
    regRead(8'h00, rd); chk("R9 restart clears halted", rd[6], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule